// File: doc/BRIEF.md
# Button Press Decade Counter

This block counts how many times a push button has been pressed, from 0 up to 9 and then back to 0. Every register runs on one free-running system clock. The button level is never used as a clock. The raw button level first passes through a two-flop synchronizer. It then goes through an optional stability filter. A three-state control machine (idle, count, wait) turns each accepted press into exactly one increment, however long the button is held.

The count is kept in a 4-bit register with a synchronous clear, a parallel load and an increment enable. On every edge it does exactly one of four things: clear, load, increment or hold. The block also gives a one-cycle pulse for each press it counts. Software-free control inputs let the surrounding logic clear the count or preset it.

Top module: `press_decade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count goes to 0, `press_pulse` goes low and the control machine goes to its idle state. The synchronizer and filter also clear to "released".
- R2: Each accepted press raises `press_pulse` for exactly one clock cycle. On the edge that ends that cycle the count increments by one, unless a clear or a load is requested on that edge. This holds whether the button is held for one cycle or for hundreds.
- R3: After a press has been counted, no further count occurs until a release has been accepted. A new press level seen while the machine is counting or waiting has no effect.
- R4: An increment from a count of 9 or more gives 0. Otherwise the count steps by one.
- R5: `clr_req` high at an edge sets the count to 0. It takes priority over both load and increment.
- R6: `ld_req` high at an edge, with no clear, loads `ld_value` into the count. It takes priority over increment.
- R7: With the filter enabled, the synchronized level must differ from the accepted level for DB_CYCLES consecutive cycles (16 by default) before the change is accepted. Shorter pulses or gaps have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Button level, active high, asynchronous to clk |
| clr_req | input | 1 | Synchronous clear of the count |
| ld_req | input | 1 | Parallel load of the count |
| ld_value | input | 4 | Value taken by a load |
| count | output | 4 | Current press count |
| press_pulse | output | 1 | One-cycle pulse for each counted press |

## Verification
The assertions check on every cycle the rules that span only one or two edges. These are the single-cycle width of the pulse, the step from count to wait, holding in wait while the level is pressed, the wrap at 9, the clear and load priorities, and that the filter output holds while its input agrees with it. Only the bench scenarios can show the end-to-end properties. These are one increment for a long hold, a bounce during the wait state being absorbed, short glitches being rejected, and the exact latency from the raw button through the synchronizer and filter. The bench shows these with its cycle-accurate reference model.

// File: rtl/press_cnt_pkg.sv
package press_cnt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WAIT  = 2'd2
    } press_state_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign dout = r_q.chain[STAGES-1];
endmodule

// File: rtl/btn_filter.sv
module btn_filter #(
    parameter int DB_EN     = 1,
    parameter int DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(DB_CYCLES + 1);

    generate
        if (DB_EN != 0) begin : g_filter
            typedef struct packed {
                logic          level;
                logic [CW-1:0] run;
            } flt_reg_t;

            flt_reg_t f_d, f_q;

            always_comb begin
                f_d = f_q;
                if (din == f_q.level) begin
                    f_d.run = '0;
                end else if (f_q.run == CW'(DB_CYCLES - 1)) begin
                    f_d.level = din;
                    f_d.run   = '0;
                end else begin
                    f_d.run = f_q.run + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) f_q <= '0;
                else     f_q <= f_d;
            end

            assign dout = f_q.level;

            AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (rst)
                (din == f_q.level) |=> $stable(f_q.level)); // R7
        end else begin : g_bypass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/press_fsm.sv
module press_fsm
    import press_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pressed,
    output logic inc_en
);
    typedef struct packed {
        press_state_t st;
    } fsm_reg_t;

    fsm_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE:  if (pressed)  s_d.st = ST_COUNT;
            ST_COUNT:               s_d.st = ST_WAIT;
            ST_WAIT:  if (!pressed) s_d.st = ST_IDLE;
            default:                s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.st <= ST_IDLE;
        else     s_q <= s_d;
    end

    assign inc_en = (s_q.st == ST_COUNT);

    AST_COUNT_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_COUNT) |=> (s_q.st == ST_WAIT)); // R2
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        inc_en |=> !inc_en); // R2
    AST_WAIT_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_WAIT && pressed) |=> (s_q.st == ST_WAIT)); // R3
endmodule

// File: rtl/decade_count.sv
module decade_count #(
    parameter int MODULUS = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         ld,
    input  logic [$clog2(MODULUS)-1:0]   ld_val,
    input  logic                         inc,
    output logic [$clog2(MODULUS)-1:0]   cnt
);
    localparam int CW   = $clog2(MODULUS);
    localparam int LAST = MODULUS - 1;

    typedef struct packed {
        logic [CW-1:0] value;
    } cnt_reg_t;

    cnt_reg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr)
            c_d.value = '0;
        else if (ld)
            c_d.value = ld_val;
        else if (inc)
            c_d.value = (c_q.value >= CW'(LAST)) ? '0 : c_q.value + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign cnt = c_q.value;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !ld && c_q.value >= CW'(LAST)) |=> (cnt == '0)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !ld && c_q.value < CW'(LAST)) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (cnt == $past(ld_val))); // R6
endmodule

// File: rtl/press_decade_counter.sv
module press_decade_counter #(
    parameter int MODULUS     = 10,
    parameter int SYNC_STAGES = 2,
    parameter int DB_EN       = 1,
    parameter int DB_CYCLES   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_raw,
    input  logic       clr_req,
    input  logic       ld_req,
    input  logic [3:0] ld_value,
    output logic [3:0] count,
    output logic       press_pulse
);
    logic btn_sync_lvl;
    logic btn_clean;
    logic inc_en;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(btn_raw), .dout(btn_sync_lvl)
    );

    btn_filter #(.DB_EN(DB_EN), .DB_CYCLES(DB_CYCLES)) u_filter (
        .clk(clk), .rst(rst), .din(btn_sync_lvl), .dout(btn_clean)
    );

    press_fsm u_fsm (
        .clk(clk), .rst(rst), .pressed(btn_clean), .inc_en(inc_en)
    );

    decade_count #(.MODULUS(MODULUS)) u_count (
        .clk(clk), .rst(rst), .clr(clr_req), .ld(ld_req),
        .ld_val(ld_value), .inc(inc_en), .cnt(count)
    );

    assign press_pulse = inc_en;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (count == 4'd0 && !press_pulse)); // R1
endmodule

// File: tb/test_press_decade_counter.sv
module test_press_decade_counter;
    localparam int DB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_raw = 1'b0;
    logic       clr_req = 1'b0;
    logic       ld_req = 1'b0;
    logic [3:0] ld_value = 4'd0;
    logic [3:0] count;
    logic       press_pulse;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit started = 0;

    // behavioural reference model
    bit m_s1, m_s2, m_db;
    int m_dbc, m_st, m_cnt;

    press_decade_counter i_press_decade_counter (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .clr_req(clr_req),
        .ld_req(ld_req), .ld_value(ld_value), .count(count),
        .press_pulse(press_pulse)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_db <= 0; m_dbc <= 0; m_st <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= btn_raw;
            m_s2 <= m_s1;
            if (m_s2 == m_db) m_dbc <= 0;
            else if (m_dbc == DB - 1) begin m_db <= m_s2; m_dbc <= 0; end
            else m_dbc <= m_dbc + 1;
            if (m_st == 0) m_st <= m_db ? 1 : 0;
            else if (m_st == 1) m_st <= 2;
            else m_st <= m_db ? 2 : 0;
            if (clr_req) m_cnt <= 0;
            else if (ld_req) m_cnt <= int'(ld_value);
            else if (m_st == 1) m_cnt <= (m_cnt >= 9) ? 0 : m_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(count === 4'(m_cnt), "R2/R4/R5/R6 count vs model", int'(count), m_cnt);
            check(press_pulse === (m_st == 1), "R2 pulse vs model", int'(press_pulse), int'(m_st == 1));
            if (press_pulse === 1'b1) pulses++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int hold);
        btn_raw = 1'b1; idle(hold);
        btn_raw = 1'b0; idle(40);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        check(count === 4'd0 && press_pulse === 1'b0, "R1 reset state", int'(count), 0);

        press(30);
        check(count === 4'd1, "R2 short hold", int'(count), 1);
        check(pulses == 1, "R2 one pulse", pulses, 1);

        press(500);
        check(count === 4'd2, "R2 long hold", int'(count), 2);
        check(pulses == 2, "R3 no repeat while held", pulses, 2);

        press(5);
        check(count === 4'd2, "R7 glitch rejected", int'(count), 2);

        btn_raw = 1'b1; idle(40);
        btn_raw = 1'b0; idle(5);
        btn_raw = 1'b1; idle(40);
        btn_raw = 1'b0; idle(40);
        check(count === 4'd3, "R3 bounce during wait ignored", int'(count), 3);

        ld_value = 4'd8; ld_req = 1'b1; idle(1); ld_req = 1'b0; idle(1);
        check(count === 4'd8, "R6 load", int'(count), 8);

        press(25);
        check(count === 4'd9, "R2 step to nine", int'(count), 9);
        press(25);
        check(count === 4'd0, "R4 wrap after nine", int'(count), 0);

        ld_value = 4'd5; ld_req = 1'b1; clr_req = 1'b1; idle(1);
        ld_req = 1'b0; clr_req = 1'b0; idle(1);
        check(count === 4'd0, "R5 clear beats load", int'(count), 0);

        ld_value = 4'd3; ld_req = 1'b1;
        press(30);
        ld_req = 1'b0; idle(1);
        check(count === 4'd3, "R6 load beats increment", int'(count), 3);

        clr_req = 1'b1;
        press(30);
        clr_req = 1'b0; idle(1);
        check(count === 4'd0, "R5 clear beats increment", int'(count), 0);

        ld_value = 4'd12; ld_req = 1'b1; idle(1); ld_req = 1'b0;
        press(25);
        check(count === 4'd0, "R4 wrap above nine", int'(count), 0);

        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        check(count === 4'd0 && press_pulse === 1'b0, "R1 reset again", int'(count), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule